// File: doc/BRIEF.md
# Transmit Start Threshold Controller

This block decides when the MAC may begin sending the frame at the head of the transmit FIFO while the loader is still copying that frame in from host memory. Each cycle it reads the FIFO byte count and the loader's end-of-frame marker. It raises a one-cycle start strobe as soon as the configured start rule is met. A later strobe is not allowed until the MAC reports that the frame is done.

Three start rules exist, and they are checked in a fixed priority order. Immediate start has the highest priority: it fires once a small fixed fill level is present. Next comes store-and-forward, which waits until a whole frame has been loaded. The lowest priority is the threshold rule. It fires at a fill level taken from one of two four-entry tables, with the speed-mode bit picking the table and a 2-bit code picking the entry. Under every rule, a frame whose last byte is already in the FIFO starts without waiting for the level. The block also drives an accept signal to the loader. Accept drops when the frame tracker is full. In single-frame mode it also drops while one complete frame is resident.

The controller is a three-state machine. IDLE means no data is waiting. ARMED means data is present but the start rule is not met yet. SEND means the strobe has been issued and the block waits for the MAC. The transitions are named as follows:
- IDLE→SEND (rule met)
- IDLE→ARMED (data present, rule not met)
- ARMED→SEND (rule met)
- ARMED→IDLE (data gone)
- SEND→IDLE (MAC done)

Top module: `tx_start_ctrl`

## Requirements
- R1: After reset, tx_start is 0 and ld_accept is 1, with no frames tracked.
- R2: With cfg_immediate=1, start fires once fifo_level ≥ IMM_LEVEL (16), whatever the values of cfg_store_fwd and cfg_thr_code.
- R3: With cfg_immediate=0 and cfg_store_fwd=1, start fires only when at least one complete frame is tracked. Fill level alone never starts a frame.
- R4: With both modes off and cfg_slow_speed=0, start fires at fifo_level ≥ 72, 96, 128 or 160 bytes for cfg_thr_code 0, 1, 2 or 3. One byte below that level does not start.
- R5: With cfg_slow_speed=1, the levels are 128, 256, 512 and 1024 bytes for codes 0, 1, 2 and 3.
- R6: A tracked complete frame starts in every mode, even when fifo_level is below the threshold.
- R7: tx_start is high for exactly one cycle. It does not fire again until mac_done has been seen in SEND. After that, a further tracked frame may start.
- R8: With cfg_one_frame=1, ld_accept goes low in the cycle after an accepted ld_eof. It stays low through the cycle in which mac_done retires that frame and returns high in the cycle after.
- R9: An ld_eof presented while ld_accept is low is not counted as a frame.
- R10: ld_accept is low while the number of tracked complete frames equals MAX_FRAMES.
- R11: mac_done outside SEND does not retire a tracked frame.
- R12: tx_start rises in the cycle after the one in which the inputs first satisfy the start rule (IDLE or ARMED). A newly accepted ld_eof counts toward the rule from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_immediate | input | 1 | Immediate-start rule enable (highest priority) |
| cfg_store_fwd | input | 1 | Whole-frame start rule enable |
| cfg_slow_speed | input | 1 | Selects the slow-link threshold table |
| cfg_thr_code | input | 2 | Threshold table index |
| cfg_one_frame | input | 1 | Allow at most one complete frame in the FIFO |
| fifo_level | input | LVL_W | Bytes currently in the transmit FIFO |
| ld_eof | input | 1 | Loader writes the last byte of a frame this cycle |
| mac_done | input | 1 | MAC finished the frame it was started on |
| tx_start | output | 1 | One-cycle start-transmit strobe |
| ld_accept | output | 1 | Loader may keep writing |

## Verification
The bench keeps the default FIFO size and both default threshold tables, so every entry in both speed tables is hit exactly at its level and one byte below it. MAX_FRAMES is lowered to 2. With that setting, the full-tracker accept drop, an ignored end-of-frame marker and a back-to-back second start can all be reached within a few frames. A stray mac_done outside SEND is placed while two frames are tracked, so a wrongly retired frame shows up at ld_accept.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2
    } tsc_state_e;

    typedef enum logic [1:0] {
        MD_IMMEDIATE = 2'd0,
        MD_STORE_FWD = 2'd1,
        MD_THRESHOLD = 2'd2
    } tsc_mode_e;

    // Fixed priority: immediate over store-and-forward over table threshold
    function automatic tsc_mode_e pick_mode(input logic imm, input logic saf);
        if (imm)      return MD_IMMEDIATE;
        else if (saf) return MD_STORE_FWD;
        else          return MD_THRESHOLD;
    endfunction

endpackage

// File: rtl/tsc_thresh_sel.sv
module tsc_thresh_sel #(
    parameter int LVL_W   = 12,
    parameter int FAST_T0 = 72,
    parameter int FAST_T1 = 96,
    parameter int FAST_T2 = 128,
    parameter int FAST_T3 = 160,
    parameter int SLOW_T0 = 128,
    parameter int SLOW_T1 = 256,
    parameter int SLOW_T2 = 512,
    parameter int SLOW_T3 = 1024
) (
    input  logic             slow,
    input  logic [1:0]       code,
    output logic [LVL_W-1:0] level_req
);
    localparam int NUM_ENT = 4;

    logic [LVL_W-1:0] fast_tab [NUM_ENT];
    logic [LVL_W-1:0] slow_tab [NUM_ENT];

    generate
        for (genvar i = 0; i < NUM_ENT; i++) begin : g_tab
            localparam int FV = (i == 0) ? FAST_T0 : (i == 1) ? FAST_T1 :
                                (i == 2) ? FAST_T2 : FAST_T3;
            localparam int SV = (i == 0) ? SLOW_T0 : (i == 1) ? SLOW_T1 :
                                (i == 2) ? SLOW_T2 : SLOW_T3;
            assign fast_tab[i] = LVL_W'(FV);
            assign slow_tab[i] = LVL_W'(SV);
        end
    endgenerate

    assign level_req = slow ? slow_tab[code] : fast_tab[code];

endmodule

// File: rtl/tsc_frame_track.sv
module tsc_frame_track #(
    parameter int MAX_FRAMES = 4,
    parameter int CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_one_frame,
    input  logic             ld_eof,
    input  logic             retire_req,
    output logic             ld_accept,
    output logic [CNT_W-1:0] frames,
    output logic             complete
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(MAX_FRAMES);

    logic eof_take;
    logic retire;

    always_comb begin
        ld_accept = (frames != FULL) && !(cfg_one_frame && (frames != '0));
        eof_take  = ld_eof && ld_accept;
        retire    = retire_req && ((frames != '0) || eof_take);
        complete  = (frames != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) frames <= '0;
        else        frames <= frames + CNT_W'(eof_take) - CNT_W'(retire);
    end

endmodule

// File: rtl/tsc_start_fsm.sv
module tsc_start_fsm
    import tsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic has_data,
    input  logic go,
    input  logic mac_done,
    output logic tx_start,
    output logic sending
);
    tsc_state_e state_q;
    tsc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go)            state_d = ST_SEND;
                else if (has_data) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (go)            state_d = ST_SEND;
                else if (!has_data) state_d = ST_IDLE;
            end
            ST_SEND: begin
                if (mac_done)      state_d = ST_IDLE;
            end
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_start <= 1'b0;
        else        tx_start <= (state_q != ST_SEND) && (state_d == ST_SEND);
    end

    assign sending = (state_q == ST_SEND);

endmodule

// File: rtl/tx_start_ctrl.sv
module tx_start_ctrl
    import tsc_pkg::*;
#(
    parameter int FIFO_BYTES = 2048,
    parameter int MAX_FRAMES = 4,
    parameter int IMM_LEVEL  = 16,
    parameter int FAST_T0    = 72,
    parameter int FAST_T1    = 96,
    parameter int FAST_T2    = 128,
    parameter int FAST_T3    = 160,
    parameter int SLOW_T0    = 128,
    parameter int SLOW_T1    = 256,
    parameter int SLOW_T2    = 512,
    parameter int SLOW_T3    = 1024,
    localparam int LVL_W     = $clog2(FIFO_BYTES + 1),
    localparam int CNT_W     = $clog2(MAX_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_immediate,
    input  logic             cfg_store_fwd,
    input  logic             cfg_slow_speed,
    input  logic [1:0]       cfg_thr_code,
    input  logic             cfg_one_frame,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             ld_eof,
    input  logic             mac_done,
    output logic             tx_start,
    output logic             ld_accept
);
    localparam logic [LVL_W-1:0] IMM_LVL = LVL_W'(IMM_LEVEL);

    logic [LVL_W-1:0] thr_level;
    logic [CNT_W-1:0] frames_q;
    logic             complete;
    logic             sending;
    logic             go;
    logic             has_data;
    tsc_mode_e        mode;

    tsc_thresh_sel #(
        .LVL_W  (LVL_W),
        .FAST_T0(FAST_T0), .FAST_T1(FAST_T1), .FAST_T2(FAST_T2), .FAST_T3(FAST_T3),
        .SLOW_T0(SLOW_T0), .SLOW_T1(SLOW_T1), .SLOW_T2(SLOW_T2), .SLOW_T3(SLOW_T3)
    ) u_thr (
        .slow     (cfg_slow_speed),
        .code     (cfg_thr_code),
        .level_req(thr_level)
    );

    tsc_frame_track #(
        .MAX_FRAMES(MAX_FRAMES),
        .CNT_W     (CNT_W)
    ) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_one_frame(cfg_one_frame),
        .ld_eof       (ld_eof),
        .retire_req   (mac_done && sending),
        .ld_accept    (ld_accept),
        .frames       (frames_q),
        .complete     (complete)
    );

    always_comb begin
        mode     = pick_mode(cfg_immediate, cfg_store_fwd);
        has_data = (fifo_level != '0) || complete;
        unique case (mode)
            MD_IMMEDIATE: go = complete || (fifo_level >= IMM_LVL);
            MD_STORE_FWD: go = complete;
            MD_THRESHOLD: go = complete || (fifo_level >= thr_level);
            default:      go = complete;
        endcase
    end

    tsc_start_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .has_data(has_data),
        .go      (go),
        .mac_done(mac_done),
        .tx_start(tx_start),
        .sending (sending)
    );

endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
    parameter int LVL_W      = 12,
    parameter int CNT_W      = 3,
    parameter int MAX_FRAMES = 4,
    parameter int IMM_LEVEL  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_immediate,
    input logic             cfg_store_fwd,
    input logic             cfg_one_frame,
    input logic [LVL_W-1:0] fifo_level,
    input logic             ld_eof,
    input logic             mac_done,
    input logic             tx_start,
    input logic             ld_accept,
    input logic [CNT_W-1:0] frames
);
    localparam logic [LVL_W-1:0] IMM_LVL = LVL_W'(IMM_LEVEL);
    localparam logic [CNT_W-1:0] FULL    = CNT_W'(MAX_FRAMES);

    logic busy;
    always_ff @(posedge clk) begin
        if (!rst_n)        busy <= 1'b0;
        else if (mac_done) busy <= 1'b0;
        else if (tx_start) busy <= 1'b1;
    end

    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tx_start);

    p_saf_whole_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && $past(!cfg_immediate && cfg_store_fwd)) |-> $past(frames != '0));

    p_imm_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && $past(cfg_immediate)) |-> ($past(fifo_level) >= IMM_LVL || $past(frames != '0)));

    p_one_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_one_frame && $past(cfg_one_frame) && $past(ld_eof && ld_accept) && !$past(mac_done))
        |-> !ld_accept);

    p_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frames == FULL) |-> !ld_accept);

    p_eof_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!ld_accept) && !$past(mac_done)) |-> $stable(frames));

endmodule

bind tx_start_ctrl tsc_checker #(
    .LVL_W     (LVL_W),
    .CNT_W     (CNT_W),
    .MAX_FRAMES(MAX_FRAMES),
    .IMM_LEVEL (IMM_LEVEL)
) u_tsc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_immediate(cfg_immediate),
    .cfg_store_fwd(cfg_store_fwd),
    .cfg_one_frame(cfg_one_frame),
    .fifo_level   (fifo_level),
    .ld_eof       (ld_eof),
    .mac_done     (mac_done),
    .tx_start     (tx_start),
    .ld_accept    (ld_accept),
    .frames       (frames_q)
);

// File: tb/test_tx_start_ctrl.sv
module test_tx_start_ctrl;
    localparam int LVL_W = 12;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_immediate, cfg_store_fwd, cfg_slow_speed, cfg_one_frame;
    logic [1:0]       cfg_thr_code;
    logic [LVL_W-1:0] fifo_level;
    logic             ld_eof, mac_done;
    logic             tx_start, ld_accept;

    int  n_chk = 0;
    int  n_err = 0;
    bit  finished = 0;

    logic  exp_q [$];
    string tag_q [$];

    always #10 clk = ~clk;

    tx_start_ctrl #(.FIFO_BYTES(2048), .MAX_FRAMES(2)) i_tx_start_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_immediate(cfg_immediate), .cfg_store_fwd(cfg_store_fwd),
        .cfg_slow_speed(cfg_slow_speed), .cfg_thr_code(cfg_thr_code),
        .cfg_one_frame(cfg_one_frame), .fifo_level(fifo_level),
        .ld_eof(ld_eof), .mac_done(mac_done),
        .tx_start(tx_start), .ld_accept(ld_accept)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Driver: one loader/MAC cycle; accept checked now, start queued for the next edge
    task automatic step(input int lvl, input bit eof, input bit done,
                        input bit exp_start, input bit exp_acc, input string tag);
        @(negedge clk);
        fifo_level = LVL_W'(lvl);
        ld_eof     = eof;
        mac_done   = done;
        #1;
        chk(tag, "ld_accept", ld_accept, exp_acc);
        exp_q.push_back(exp_start);
        tag_q.push_back(tag);
    endtask

    task automatic set_cfg(input bit imm, input bit saf, input bit slow,
                           input int code, input bit one);
        cfg_immediate  = imm;
        cfg_store_fwd  = saf;
        cfg_slow_speed = slow;
        cfg_thr_code   = 2'(code);
        cfg_one_frame  = one;
    endtask

    function automatic int thr_of(input int slow, input int code);
        if (slow != 0) return 128 << code;
        case (code)
            0: return 72;
            1: return 96;
            2: return 128;
            default: return 160;
        endcase
    endfunction

    // Monitor: pops one expectation per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, "tx_start", tx_start, e);
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        set_cfg(0, 0, 0, 0, 0);
        fifo_level = '0;
        ld_eof = 1'b0;
        mac_done = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "tx_start", tx_start, 1'b0);
        chk("R1", "ld_accept", ld_accept, 1'b1);
        rst_n = 1'b1;

        // R2 / R12: immediate start overrides store-and-forward and code
        set_cfg(1, 1, 0, 3, 0);
        step(8,  0, 0, 0, 1, "R2");
        step(15, 0, 0, 0, 1, "R2");
        step(16, 0, 0, 1, 1, "R12");
        step(40, 0, 0, 0, 1, "R7");
        step(60, 1, 0, 0, 1, "R7");
        step(60, 0, 0, 0, 1, "R7");
        step(0,  0, 1, 0, 1, "R7");
        step(0,  0, 0, 0, 1, "R7");

        // R3: whole frame required
        set_cfg(0, 1, 0, 0, 0);
        step(200,  0, 0, 0, 1, "R3");
        step(1500, 0, 0, 0, 1, "R3");
        step(1600, 1, 0, 0, 1, "R3");
        step(1600, 0, 0, 1, 1, "R3");
        step(1600, 0, 0, 0, 1, "R3");
        step(0,    0, 1, 0, 1, "R3");
        step(0,    0, 0, 0, 1, "R3");

        // R4 / R5: every table entry at and one below its level
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 4; c++) begin
                string tg;
                int    t;
                tg = (s != 0) ? "R5" : "R4";
                t  = thr_of(s, c);
                set_cfg(0, 0, s[0], c, 0);
                step(t - 1, 0, 0, 0, 1, tg);
                step(t,     0, 0, 1, 1, tg);
                step(t,     1, 0, 0, 1, tg);
                step(0,     0, 1, 0, 1, tg);
                step(0,     0, 0, 0, 1, tg);
            end
        end

        // R6: complete frame below the threshold
        set_cfg(0, 0, 1, 3, 0);
        step(300, 1, 0, 0, 1, "R6");
        step(300, 0, 0, 1, 1, "R6");
        step(300, 0, 0, 0, 1, "R6");
        step(0,   0, 1, 0, 1, "R6");
        step(0,   0, 0, 0, 1, "R6");

        // R8 / R9: single-frame mode, eof while blocked is dropped
        set_cfg(0, 1, 0, 0, 1);
        step(100, 0, 0, 0, 1, "R8");
        step(200, 1, 0, 0, 1, "R8");
        step(200, 0, 0, 1, 0, "R8");
        step(200, 0, 0, 0, 0, "R8");
        step(200, 1, 0, 0, 0, "R9");
        step(0,   0, 1, 0, 0, "R8");
        step(0,   0, 0, 0, 1, "R8");
        set_cfg(0, 1, 0, 0, 0);
        step(0,   0, 0, 0, 1, "R9");
        step(0,   0, 0, 0, 1, "R9");

        // R10 / R7: tracker full, then back-to-back second frame
        step(50,  1, 0, 0, 1, "R10");
        step(100, 1, 0, 1, 1, "R10");
        step(100, 0, 0, 0, 0, "R10");
        step(100, 1, 0, 0, 0, "R9");
        step(100, 0, 1, 0, 0, "R10");
        step(100, 0, 0, 1, 1, "R7");
        step(0,   0, 1, 0, 1, "R7");
        step(0,   0, 0, 0, 1, "R9");
        step(0,   0, 0, 0, 1, "R9");

        // R11: stray mac_done while not sending
        step(0, 1, 0, 0, 1, "R11");
        step(0, 1, 1, 1, 1, "R11");
        step(0, 0, 0, 0, 0, "R11");
        step(0, 0, 1, 0, 0, "R11");
        step(0, 0, 0, 1, 1, "R11");
        step(0, 0, 1, 0, 1, "R11");
        step(0, 0, 0, 0, 1, "R11");
        step(0, 0, 0, 0, 1, "R11");

        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        summary();
    end

endmodule